// File: doc/BRIEF.md
# Event-Triggered Serial Control-Word Transmitter

This block sends short control words to an external RF transceiver over a three-wire serial link. The link has a serial clock, one data line and two chip-selects, one for each of two target devices. Firmware loads a bank of slots through a simple write-only register bus. Each slot holds a data word and a control word. The control word gives the frame length, the target device and a 5-bit trigger event number. An external timer pulses event numbers. Every slot whose event number matches the pulse is queued for transmission. Slots tagged with the reserved immediate event number are never matched by the timer. They are queued by a trigger bit in the global control word instead.

Queued slots go out one frame at a time, lowest slot index first. Each frame is shifted MSB first, starting from bit (length-1) of the data word. The serial clock is the system clock divided by 2, 4, 6 or 8, and its polarity is selectable. The chip-select of the chosen device frames the transfer. By default it opens one serial period before the first bit and closes one serial period after the last bit. A per-device short option drops both guard periods. Chip-select polarity is also selectable per device. A busy output covers each frame in flight, and a one-cycle done pulse marks its end. A typical frame for the transceiver is 26 bits: a 4-bit register address in the low nibble and the register value above it.

Top module: `sctl_xmit`

## Requirements
- R1: After reset all slot words and the global word are zero: ser_clk is low, both chip-selects are high (deasserted), ser_data is low, and busy and done are low.
- R2: The serial clock period during a frame is 2*(S+1) system cycles, where S is global bits [2:1].
- R3: Global bit 0 sets the serial clock's inactive (idle) level. The active level is its inverse, and outside a frame the clock rests at the idle level.
- R4: A frame carries L = (slot control bits [14:8]) + 1 bits, taken MSB first from data bit L-1 down to bit 0. Bit positions at 32 or above are sent as 0. ser_data is 0 outside a frame.
- R5: ser_data changes only together with a transition to the inactive clock level, so it is stable across every active clock transition.
- R6: Slot control bit 15 selects chip-select 1, otherwise chip-select 0. The other chip-select stays deasserted, and the two are never asserted together.
- R7: Global bits 5 and 7 make chip-select 0 and 1 active-high (default active-low). With global bits 4 and 6 clear, the selected chip-select is asserted for (L+2) serial periods, which includes one guard period before and one after the bits. With bit 4 or 6 set, the guard periods are dropped and it is asserted for L periods.
- R8: A timer pulse (evt_valid with evt_id) queues every slot whose control bits [4:0] equal evt_id. A pulse with evt_id 0x1F, or one that matches no slot, queues nothing.
- R9: A global write with bit 3 set queues every slot whose event field is 0x1F. Bit 3 itself is not stored.
- R10: Frames go out one at a time. Pending slots are served in ascending slot index, including triggers that arrive while busy. busy is high exactly while a frame is in flight, and done pulses for one cycle as each frame ends.
- R11: Slot writes (address 2i+1 for control, 2i+2 for data of slot i, address 0 for the global word) take effect only while global bit 8 is set. Otherwise they are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 global, 2i+1 / 2i+2 slot i control / data |
| bus_wdata | input | DATA_W | Register write data |
| evt_valid | input | 1 | Timer event pulse |
| evt_id | input | 5 | Timer event number |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_cs0 | output | 1 | Chip-select of device 0 |
| ser_cs1 | output | 1 | Chip-select of device 1 |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A wrong half-period counter or phase bit shows up at once as a serial clock period or chip-select window of the wrong length. It also shows up as a data change that coincides with an active clock edge. A wrong bit index corrupts the captured frame within the same frame. It can also make the frame one bit too long or too short, which stretches the chip-select window. A stuck or mis-cleared pending bit appears one frame later, as a repeated, missing or out-of-order frame. A wrong event comparison appears as a frame where none should start, so the bench watches quiet windows as well as active ones.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int EVT_W = 5;
    localparam int LEN_W = 7;
    localparam int DIV_W = 2;
    localparam logic [EVT_W-1:0] EVT_IMMEDIATE = 5'h1F;

    // Line configuration seen by the shifter
    typedef struct packed {
        logic             cs1_inv;
        logic             cs1_short;
        logic             cs0_inv;
        logic             cs0_short;
        logic [DIV_W-1:0] div_sel;
        logic             clk_inv;
    } line_cfg_t;

    typedef struct packed {
        logic      direct_wr;
        line_cfg_t line;
    } gcfg_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LEAD,
        SH_BITS,
        SH_TRAIL
    } sh_state_e;

    function automatic gcfg_t decode_gcfg(input logic [15:0] w);
        gcfg_t c;
        c.line.clk_inv   = w[0];
        c.line.div_sel   = w[2:1];
        c.line.cs0_short = w[4];
        c.line.cs0_inv   = w[5];
        c.line.cs1_short = w[6];
        c.line.cs1_inv   = w[7];
        c.direct_wr      = w[8];
        return c;
    endfunction

endpackage

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int IDX_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic                              evt_valid,
    input  logic [EVT_W-1:0]                  evt_id,
    input  logic                              launch,
    input  logic [IDX_W-1:0]                  launch_idx,
    output line_cfg_t                         line_cfg,
    output logic [NUM_SLOTS-1:0][LEN_W-1:0]   slot_len_m1,
    output logic [NUM_SLOTS-1:0]              slot_dev1,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_data,
    output logic [NUM_SLOTS-1:0]              pend
);

    typedef struct packed {
        gcfg_t                             cfg;
        logic [NUM_SLOTS-1:0][EVT_W-1:0]   evt;
        logic [NUM_SLOTS-1:0][LEN_W-1:0]   len_m1;
        logic [NUM_SLOTS-1:0]              dev1;
        logic [NUM_SLOTS-1:0][DATA_W-1:0]  data;
        logic [NUM_SLOTS-1:0]              pend;
    } reg_state_t;

    reg_state_t s_d, s_q;

    logic                 gwrite;
    logic                 imm_fire;
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] clr_mask;

    assign gwrite   = bus_we && (bus_addr == '0);
    assign imm_fire = gwrite && bus_wdata[3];
    assign clr_mask = launch ? (NUM_SLOTS'(1) << launch_idx) : '0;

    // Per-slot trigger match
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
        assign hit[g] = (evt_valid && (evt_id != EVT_IMMEDIATE) && (s_q.evt[g] == evt_id))
                     || (imm_fire && (s_q.evt[g] == EVT_IMMEDIATE));
    end

    always_comb begin
        s_d = s_q;
        if (gwrite) begin
            s_d.cfg = decode_gcfg(bus_wdata[15:0]);
        end else if (bus_we && s_q.cfg.direct_wr) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (bus_addr == ADDR_W'(2 * i + 1)) begin
                    s_d.evt[i]    = bus_wdata[EVT_W-1:0];
                    s_d.len_m1[i] = bus_wdata[8 +: LEN_W];
                    s_d.dev1[i]   = bus_wdata[15];
                end
                if (bus_addr == ADDR_W'(2 * i + 2)) begin
                    s_d.data[i] = bus_wdata;
                end
            end
        end
        // a new trigger wins over the clear of the slot just launched
        s_d.pend = (s_q.pend & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_cfg    = s_q.cfg.line;
    assign slot_len_m1 = s_q.len_m1;
    assign slot_dev1   = s_q.dev1;
    assign slot_data   = s_q.data;
    assign pend        = s_q.pend;

endmodule

// File: rtl/sctl_pick.sv
module sctl_pick #(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sctl_shift.sv
module sctl_shift
    import sctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              dev1,
    input  logic [DATA_W-1:0] data,
    input  line_cfg_t         cfg,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_cs0,
    output logic              ser_cs1,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        sh_state_e         st;
        logic              phase;
        logic [DIV_W-1:0]  cnt;
        logic [DIV_W-1:0]  half_m1;
        logic [LEN_W-1:0]  bit_idx;
        logic              dev1;
        logic              shrt;
        logic [DATA_W-1:0] data;
        logic              o_clk;
        logic              o_dat;
        logic              o_cs0;
        logic              o_cs1;
        logic              done;
    } sh_t;

    sh_t  s_d, s_q;
    logic adv;
    logic fin;
    logic first_short;
    logic active;

    function automatic logic fetch_bit(input logic [DATA_W-1:0] d,
                                       input logic [LEN_W-1:0] k);
        int unsigned n;
        n = int'(k);
        if (n < DATA_W) begin
            return d[n];
        end
        return 1'b0;
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        adv         = 1'b0;
        fin         = 1'b0;
        first_short = dev1 ? cfg.cs1_short : cfg.cs0_short;

        if (s_q.st == SH_IDLE) begin
            if (start) begin
                s_d.dev1    = dev1;
                s_d.shrt    = first_short;
                s_d.half_m1 = cfg.div_sel;
                s_d.bit_idx = len_m1;
                s_d.data    = data;
                s_d.phase   = 1'b0;
                s_d.cnt     = '0;
                s_d.st      = first_short ? SH_BITS : SH_LEAD;
            end
        end else begin
            if (s_q.cnt == s_q.half_m1) begin
                s_d.cnt   = '0;
                s_d.phase = ~s_q.phase;
                adv       = s_q.phase;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (adv) begin
                case (s_q.st)
                    SH_LEAD:  s_d.st = SH_BITS;
                    SH_BITS: begin
                        if (s_q.bit_idx == '0) begin
                            if (s_q.shrt) begin
                                fin = 1'b1;
                            end else begin
                                s_d.st = SH_TRAIL;
                            end
                        end else begin
                            s_d.bit_idx = s_q.bit_idx - 1'b1;
                        end
                    end
                    default:  fin = 1'b1;
                endcase
            end
        end

        if (fin) begin
            s_d.st   = SH_IDLE;
            s_d.done = 1'b1;
        end

        // registered line levels follow the next state
        active    = (s_d.st != SH_IDLE);
        s_d.o_clk = cfg.clk_inv ^ ((s_d.st == SH_BITS) && s_d.phase);
        s_d.o_dat = (s_d.st == SH_BITS) ? fetch_bit(s_d.data, s_d.bit_idx) : 1'b0;
        s_d.o_cs0 = (active && !s_d.dev1) ? cfg.cs0_inv : ~cfg.cs0_inv;
        s_d.o_cs1 = (active &&  s_d.dev1) ? cfg.cs1_inv : ~cfg.cs1_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.o_cs0 <= 1'b1;
            s_q.o_cs1 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_clk  = s_q.o_clk;
    assign ser_data = s_q.o_dat;
    assign ser_cs0  = s_q.o_cs0;
    assign ser_cs1  = s_q.o_cs1;
    assign busy     = (s_q.st != SH_IDLE);
    assign done     = s_q.done;

endmodule

// File: rtl/sctl_xmit.sv
module sctl_xmit
    import sctl_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    parameter  int DATA_W    = 32,
    localparam int ADDR_W    = $clog2(2 * NUM_SLOTS + 1),
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              evt_valid,
    input  logic [4:0]        evt_id,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_cs0,
    output logic              ser_cs1,
    output logic              busy,
    output logic              done
);

    line_cfg_t                        line_cfg;
    logic [NUM_SLOTS-1:0][LEN_W-1:0]  slot_len_m1;
    logic [NUM_SLOTS-1:0]             slot_dev1;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [NUM_SLOTS-1:0]             pend;
    logic                             pick_any;
    logic [IDX_W-1:0]                 pick_idx;
    logic                             start;

    // configuration taps for the bound checker
    logic cfg_clk_inv;
    logic cfg_cs0_inv;
    logic cfg_cs1_inv;

    assign start       = pick_any && !busy;
    assign cfg_clk_inv = line_cfg.clk_inv;
    assign cfg_cs0_inv = line_cfg.cs0_inv;
    assign cfg_cs1_inv = line_cfg.cs1_inv;

    sctl_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .evt_valid   (evt_valid),
        .evt_id      (evt_id),
        .launch      (start),
        .launch_idx  (pick_idx),
        .line_cfg    (line_cfg),
        .slot_len_m1 (slot_len_m1),
        .slot_dev1   (slot_dev1),
        .slot_data   (slot_data),
        .pend        (pend)
    );

    sctl_pick #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .req (pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    sctl_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_m1   (slot_len_m1[pick_idx]),
        .dev1     (slot_dev1[pick_idx]),
        .data     (slot_data[pick_idx]),
        .cfg      (line_cfg),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_cs0  (ser_cs0),
        .ser_cs1  (ser_cs1),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: rtl/sctl_xmit_chk.sv
module sctl_xmit_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_cs0,
    input logic ser_cs1,
    input logic busy,
    input logic done,
    input logic clk_pol,
    input logic cs0_inv,
    input logic cs1_inv
);

    AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_clk == $past(clk_pol))); // R3

    AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_data); // R4

    AST_DATA_STABLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ser_clk != $past(ser_clk)) && (ser_clk != $past(clk_pol))) |-> $stable(ser_data)); // R5

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((ser_cs0 == $past(cs0_inv)) && (ser_cs1 == $past(cs1_inv)))); // R6

    AST_IDLE_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((ser_cs0 != $past(cs0_inv)) && (ser_cs1 != $past(cs1_inv)))); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10

endmodule

bind sctl_xmit sctl_xmit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_cs0  (ser_cs0),
    .ser_cs1  (ser_cs1),
    .busy     (busy),
    .done     (done),
    .clk_pol  (cfg_clk_inv),
    .cs0_inv  (cfg_cs0_inv),
    .cs1_inv  (cfg_cs1_inv)
);

// File: tb/sctl_xmit_bench.sv
module sctl_xmit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_id = '0;
    logic        ser_clk, ser_data, ser_cs0, ser_cs1, busy, done;

    always #10 clk = ~clk;

    sctl_xmit u_sctl_xmit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt_valid (evt_valid),
        .evt_id    (evt_id),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_cs0   (ser_cs0),
        .ser_cs1   (ser_cs1),
        .busy      (busy),
        .done      (done)
    );

    int checks = 0;
    int errors = 0;

    // bench view of the line configuration
    logic tb_pol = 1'b0, tb_cs0_inv = 1'b0, tb_cs1_inv = 1'b0;
    logic mon_en = 1'b1;

    // frame monitor state
    logic        in_frame = 1'b0;
    logic        prev_clk = 1'b0;
    logic        prev_dat = 1'b0;
    logic        cur_dev;
    logic [63:0] cur_bits;
    int          cur_n, cur_cyc, cur_per, last_edge;
    int          cyc = 0;
    int          nrec = 0;
    int          ndone = 0;
    int          both_err = 0;
    int          stab_err = 0;
    logic        rec_dev  [0:255];
    logic [63:0] rec_bits [0:255];
    int          rec_n    [0:255];
    int          rec_cyc  [0:255];
    int          rec_per  [0:255];

    always @(negedge clk) begin
        if (rst_n) begin
            logic a0, a1;
            a0 = mon_en && (ser_cs0 == tb_cs0_inv);
            a1 = mon_en && (ser_cs1 == tb_cs1_inv);
            if (done) ndone++;
            if (a0 && a1) both_err++;
            if (a0 || a1) begin
                if (!in_frame) begin
                    in_frame  = 1'b1;
                    cur_dev   = a1;
                    cur_bits  = '0;
                    cur_n     = 0;
                    cur_cyc   = 0;
                    cur_per   = 0;
                    last_edge = -1;
                end
                cur_cyc++;
                if ((ser_clk != prev_clk) && (ser_clk != tb_pol)) begin
                    if (cur_cyc > 1 && ser_data != prev_dat) stab_err++;
                    cur_bits = {cur_bits[62:0], ser_data};
                    cur_n++;
                    if (last_edge >= 0) cur_per = cyc - last_edge;
                    last_edge = cyc;
                end
            end else if (in_frame) begin
                in_frame       = 1'b0;
                rec_dev[nrec]  = cur_dev;
                rec_bits[nrec] = cur_bits;
                rec_n[nrec]    = cur_n;
                rec_cyc[nrec]  = cur_cyc;
                rec_per[nrec]  = cur_per;
                nrec++;
            end
            prev_clk = ser_clk;
            prev_dat = ser_data;
            cyc++;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input int addr, input logic [31:0] w);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 5'(addr);
        bus_wdata = w;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic set_cfg(input logic [31:0] w);
        mon_en = 1'b0;
        bus_write(0, w);
        repeat (3) @(negedge clk);
        tb_pol     = w[0];
        tb_cs0_inv = w[5];
        tb_cs1_inv = w[7];
        mon_en     = 1'b1;
    endtask

    task automatic pulse_evt(input int id);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_id    = 5'(id);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wait_frames(input int target, input string req);
        int t = 0;
        while (nrec < target && t < 20000) begin
            @(posedge clk);
            t++;
        end
        if (nrec < target) check({req, " frame count"}, 64'(nrec), 64'(target));
        repeat (2) @(posedge clk);
    endtask

    function automatic logic [31:0] ctlw(input int ev, input int len, input int dev);
        return 32'((dev << 15) | ((len - 1) << 8) | ev);
    endfunction

    function automatic logic [63:0] low_mask(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        finish_sim();
    end

    initial begin
        int base;
        logic [31:0] d;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset levels
        check("R1 ser_clk", 64'(ser_clk), 0);
        check("R1 ser_cs0", 64'(ser_cs0), 1);
        check("R1 ser_cs1", 64'(ser_cs1), 1);
        check("R1 ser_data", 64'(ser_data), 0);
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);

        // R11: slot writes with direct-write clear are dropped; zeroed slots all fire on event 0
        bus_write(1, ctlw(5, 26, 1));
        bus_write(2, 32'h0012_3456);
        base = nrec;
        pulse_evt(0);
        wait_frames(base + 8, "R11");
        check("R11 ignored ctl length", 64'(rec_n[base]), 1);
        check("R11 ignored ctl device", 64'(rec_dev[base]), 0);
        check("R11 ignored data", rec_bits[base], 0);

        // enable direct writes, park all slots on event 30
        set_cfg(32'h100);
        for (int i = 0; i < 8; i++) bus_write(2 * i + 1, ctlw(30, 1, 0));

        // R2 R3 R4 R7 sweep: divider x clock polarity x short mode, 26-bit frames
        for (int sel = 0; sel < 4; sel++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int sh = 0; sh < 2; sh++) begin
                    set_cfg(32'(32'h100 | inv | (sel << 1) | (sh << 4)));
                    check("R3 idle clock level", 64'(ser_clk), 64'(inv));
                    d = 32'(((32'h2A5C3 + sel * 977 + inv * 31 + sh * 7) << 4) | (sel * 4 + inv * 2 + sh));
                    bus_write(1, ctlw(3, 26, 0));
                    bus_write(2, d);
                    base = nrec;
                    pulse_evt(3);
                    wait_frames(base + 1, "R4");
                    check("R4 26-bit frame bits", rec_bits[base], 64'(d) & low_mask(26));
                    check("R4 26-bit frame length", 64'(rec_n[base]), 26);
                    check("R2 serial period", 64'(rec_per[base]), 64'(2 * (sel + 1)));
                    check("R7 cs0 window", 64'(rec_cyc[base]), 64'((26 + (sh ? 0 : 2)) * 2 * (sel + 1)));
                    check("R6 device 0", 64'(rec_dev[base]), 0);
                end
            end
        end

        // R4 length sweep including lengths past the data width
        set_cfg(32'h100);
        for (int len = 1; len <= 40; len++) begin
            d = 32'hA5C3_96E1;
            bus_write(1, ctlw(3, len, 0));
            bus_write(2, d);
            base = nrec;
            pulse_evt(3);
            wait_frames(base + 1, "R4");
            check("R4 length sweep bits", rec_bits[base], (len >= 32) ? 64'(d) : (64'(d) & low_mask(len)));
            check("R4 length sweep count", 64'(rec_n[base]), 64'(len));
        end

        // R6 R7 device 1 with polarity and short options
        for (int inv1 = 0; inv1 < 2; inv1++) begin
            for (int sh1 = 0; sh1 < 2; sh1++) begin
                set_cfg(32'(32'h100 | (inv1 << 7) | (sh1 << 6)));
                check("R7 cs1 idle level", 64'(ser_cs1), 64'(!inv1));
                d = 32'(32'h0155_5A1 + inv1 * 16 + sh1);
                bus_write(1, ctlw(3, 26, 1));
                bus_write(2, d);
                base = nrec;
                pulse_evt(3);
                wait_frames(base + 1, "R6");
                check("R6 device 1 selected", 64'(rec_dev[base]), 1);
                check("R6 device 1 bits", rec_bits[base], 64'(d) & low_mask(26));
                check("R7 cs1 window", 64'(rec_cyc[base]), 64'((26 + (sh1 ? 0 : 2)) * 2));
            end
        end
        set_cfg(32'h100);

        // R8: reserved ID and unmatched IDs start nothing
        bus_write(1, ctlw(31, 26, 0));
        bus_write(2, 32'h0ABC_DEF1);
        base = nrec;
        pulse_evt(31);
        repeat (200) @(posedge clk);
        check("R8 reserved id not matched", 64'(nrec), 64'(base));
        pulse_evt(4);
        repeat (200) @(posedge clk);
        check("R8 unmatched id", 64'(nrec), 64'(base));
        @(negedge clk);
        check("R8 idle after pulses", 64'(busy), 0);

        // R9: immediate trigger sends slots 0 and 3 in order
        bus_write(7, ctlw(31, 26, 0));
        bus_write(8, 32'h0133_3333);
        base = nrec;
        bus_write(0, 32'h108);
        wait_frames(base + 2, "R9");
        check("R9 first immediate frame", rec_bits[base], 64'h0ABC_DEF1 & low_mask(26));
        check("R9 second immediate frame", rec_bits[base + 1], 64'h0133_3333);
        base = nrec;
        repeat (200) @(posedge clk);
        check("R9 trigger bit not kept", 64'(nrec), 64'(base));

        // R10: queued order, busy and done
        bus_write(1, ctlw(30, 1, 0));
        bus_write(7, ctlw(30, 1, 0));
        bus_write(13, ctlw(9, 26, 0));  bus_write(14, 32'h0066_6666);
        bus_write(3, ctlw(7, 26, 0));   bus_write(4, 32'h0011_1111);
        bus_write(5, ctlw(7, 26, 0));   bus_write(6, 32'h0022_2222);
        bus_write(11, ctlw(7, 26, 0));  bus_write(12, 32'h0055_5555);
        base = nrec;
        begin
            int d0;
            d0 = ndone;
            pulse_evt(9);
            repeat (4) @(negedge clk);
            check("R10 busy in frame", 64'(busy), 1);
            pulse_evt(7);
            wait_frames(base + 4, "R10");
            check("R10 order slot 6", rec_bits[base], 64'h0066_6666);
            check("R10 order slot 1", rec_bits[base + 1], 64'h0011_1111);
            check("R10 order slot 2", rec_bits[base + 2], 64'h0022_2222);
            check("R10 order slot 5", rec_bits[base + 3], 64'h0055_5555);
            check("R10 done pulses", 64'(ndone - d0), 4);
            @(negedge clk);
            check("R10 busy after queue", 64'(busy), 0);
        end

        check("R6 never both selected", 64'(both_err), 0);
        check("R5 data stable at active edge", 64'(stab_err), 0);
        finish_sim();
    end

endmodule